// File: doc/BRIEF.md
# Multidrop Test-Bus Address Selector

Many boards share one backplane test bus: clock, mode select, data in and data out. Each board carries one of these selectors. It runs a full boundary-scan TAP state machine on the backplane mode select line, whether or not it has been picked. It also holds a six-bit instruction register. At every Update-IR the value just shifted in is treated as an address and compared with the board's static slot pins. The board is picked when the code equals its own slot. It is also picked when the code is the broadcast code, or a multicast group code whose enable bit is set in the board's group register.

Only a board picked by its own unique address drives the shared data output. A board picked by broadcast or multicast keeps the line released, so several picked boards never fight over it. A uniquely picked board exposes its four-bit group enable register as its data register, so the test master can set group membership one board at a time. The selected flag goes to the local scan-port router, which is a separate block.

Top module: `mdAddrSelect`

## Requirements
- R1: While trstN is low, and after it rises, selected is 0 and tdoEn is 0. The TAP is held in Test-Logic-Reset and the group register is cleared to 0.
- R2: Every clock edge taken in Test-Logic-Reset clears selected and the group register. Five clocks with tms high reach that state from any state.
- R3: At Update-IR, a code in 0..58 that equals slotId sets selected and marks the selection as unique. The IR shifts LSB first, tdi entering at bit 5.
- R4: At Update-IR, a code in 0..58 that differs from slotId clears selected.
- R5: Code 63 is broadcast. It sets selected on every board, and tdoEn stays 0 for as long as that selection lasts.
- R6: Codes 59, 60, 61 and 62 are groups 0 to 3. At Update-IR a group code sets selected when group register bit (code-59) is 1, and clears it otherwise. tdoEn stays 0 for as long as a group selection lasts.
- R7: While uniquely selected, a DR scan shifts the 4-bit group register LSB first, with bit 0 being group 0. Capture-DR loads the current contents, which appear on tdo. Update-DR commits the shifted value. When not uniquely selected, Update-DR leaves the register unchanged.
- R8: tdoEn is 1 only in Shift-IR or Shift-DR, and only while uniquely selected. A deselected board keeps tdoEn at 0 through whole scans while still following the TAP states.
- R9: Capture-IR loads 6'b000001 into the IR, so a uniquely selected board shifts out 1 and then five 0s during Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Backplane test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Backplane mode select |
| tdi | input | 1 | Backplane serial data in |
| slotId | input | 6 | Static slot address pins |
| tdo | output | 1 | Serial data out, valid while tdoEn is 1 |
| tdoEn | output | 1 | Drive enable for the shared data line |
| selected | output | 1 | Board picked by unique, broadcast or group code |

## Verification
If the TAP state drifts from the bus, the next address scan lands in the wrong register or misses Update-IR. The selected flag is then wrong right after that scan's final clock. A wrong selection kind shows during the next shift phase: tdoEn rises where it must stay low, or stays low where the capture pattern should appear. Group register damage only shows later, at a group select or at the next DR scan of the same board, which returns its old contents on tdo.

// File: rtl/mdSelPkg.sv
package mdSelPkg;

  typedef enum logic [3:0] {
    TLR, RTI,
    SEL_DR, CAP_DR, SHIFT_DR, EXIT1_DR, PAUSE_DR, EXIT2_DR, UPD_DR,
    SEL_IR, CAP_IR, SHIFT_IR, EXIT1_IR, PAUSE_IR, EXIT2_IR, UPD_IR
  } tapState_e;

  typedef struct packed {
    logic inReset;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapStrobe_t;

  function automatic tapState_e tapNext(tapState_e cur, logic tms);
    case (cur)
      TLR:      return tms ? TLR      : RTI;
      RTI:      return tms ? SEL_DR   : RTI;
      SEL_DR:   return tms ? SEL_IR   : CAP_DR;
      CAP_DR:   return tms ? EXIT1_DR : SHIFT_DR;
      SHIFT_DR: return tms ? EXIT1_DR : SHIFT_DR;
      EXIT1_DR: return tms ? UPD_DR   : PAUSE_DR;
      PAUSE_DR: return tms ? EXIT2_DR : PAUSE_DR;
      EXIT2_DR: return tms ? UPD_DR   : SHIFT_DR;
      UPD_DR:   return tms ? SEL_DR   : RTI;
      SEL_IR:   return tms ? TLR      : CAP_IR;
      CAP_IR:   return tms ? EXIT1_IR : SHIFT_IR;
      SHIFT_IR: return tms ? EXIT1_IR : SHIFT_IR;
      EXIT1_IR: return tms ? UPD_IR   : PAUSE_IR;
      PAUSE_IR: return tms ? EXIT2_IR : PAUSE_IR;
      EXIT2_IR: return tms ? UPD_IR   : SHIFT_IR;
      UPD_IR:   return tms ? SEL_DR   : RTI;
      default:  return TLR;
    endcase
  endfunction

endpackage

// File: rtl/mdTapCtrl.sv
module mdTapCtrl
  import mdSelPkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  output tapState_e  state,
  output tapStrobe_t strobe
);

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= TLR;
    else        state <= tapNext(state, tms);
  end

  always_comb begin
    strobe           = '0;
    strobe.inReset   = (state == TLR);
    strobe.captureIr = (state == CAP_IR);
    strobe.shiftIr   = (state == SHIFT_IR);
    strobe.updateIr  = (state == UPD_IR);
    strobe.captureDr = (state == CAP_DR);
    strobe.shiftDr   = (state == SHIFT_DR);
    strobe.updateDr  = (state == UPD_DR);
  end

endmodule

// File: rtl/mdAddrPath.sv
module mdAddrPath
  import mdSelPkg::*;
#(
  parameter int ADDR_BITS   = 6,
  parameter int GROUP_COUNT = 4
) (
  input  logic                   tck,
  input  logic                   trstN,
  input  logic                   tdi,
  input  tapStrobe_t             strobe,
  input  logic [ADDR_BITS-1:0]   slotId,
  output logic                   selected,
  output logic                   uniqueSel,
  output logic [ADDR_BITS-1:0]   irShift,
  output logic [GROUP_COUNT-1:0] groupEn,
  output logic                   tdo
);

  localparam int CODE_TOP   = (1 << ADDR_BITS) - 1;
  localparam int GROUP_BASE = CODE_TOP - GROUP_COUNT;
  localparam logic [ADDR_BITS-1:0] IR_CAPTURE = ADDR_BITS'(1);

  logic [GROUP_COUNT-1:0] grpShift;
  logic [GROUP_COUNT-1:0] groupHitVec;
  logic [ADDR_BITS:0]     irCat;
  logic [GROUP_COUNT:0]   grpCat;
  logic isBcast, isGroup, uniqueHit, groupHit;

  // one comparator per multicast group
  for (genvar g = 0; g < GROUP_COUNT; g++) begin : gHit
    assign groupHitVec[g] = groupEn[g] && (irShift == ADDR_BITS'(GROUP_BASE + g));
  end

  always_comb begin
    isBcast   = (irShift == ADDR_BITS'(CODE_TOP));
    isGroup   = (irShift >= ADDR_BITS'(GROUP_BASE)) && !isBcast;
    groupHit  = |groupHitVec;
    uniqueHit = !isGroup && !isBcast && (irShift == slotId);
    irCat     = {tdi, irShift};
    grpCat    = {tdi, grpShift};
    tdo       = strobe.shiftDr ? grpShift[0] : irShift[0];
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      selected  <= 1'b0;
      uniqueSel <= 1'b0;
      groupEn   <= '0;
      irShift   <= IR_CAPTURE;
      grpShift  <= '0;
    end else if (strobe.inReset) begin
      selected  <= 1'b0;
      uniqueSel <= 1'b0;
      groupEn   <= '0;
    end else begin
      if (strobe.captureIr) irShift <= IR_CAPTURE;
      if (strobe.shiftIr)   irShift <= irCat[ADDR_BITS:1];
      if (strobe.updateIr) begin
        selected  <= uniqueHit || isBcast || groupHit;
        uniqueSel <= uniqueHit;
      end
      if (strobe.captureDr) grpShift <= groupEn;
      if (strobe.shiftDr)   grpShift <= grpCat[GROUP_COUNT:1];
      if (strobe.updateDr && uniqueSel) groupEn <= grpShift;
    end
  end

endmodule

// File: rtl/mdAddrSelect.sv
module mdAddrSelect
  import mdSelPkg::*;
#(
  parameter int ADDR_BITS   = 6,
  parameter int GROUP_COUNT = 4
) (
  input  logic                 tck,
  input  logic                 trstN,
  input  logic                 tms,
  input  logic                 tdi,
  input  logic [ADDR_BITS-1:0] slotId,
  output logic                 tdo,
  output logic                 tdoEn,
  output logic                 selected
);

  tapState_e              tapState;
  tapStrobe_t             strobe;
  logic                   uniqueSel;
  logic [ADDR_BITS-1:0]   irShift;
  logic [GROUP_COUNT-1:0] groupEn;

  mdTapCtrl ctrl (
    .tck    (tck),
    .trstN  (trstN),
    .tms    (tms),
    .state  (tapState),
    .strobe (strobe)
  );

  mdAddrPath #(.ADDR_BITS(ADDR_BITS), .GROUP_COUNT(GROUP_COUNT)) path (
    .tck       (tck),
    .trstN     (trstN),
    .tdi       (tdi),
    .strobe    (strobe),
    .slotId    (slotId),
    .selected  (selected),
    .uniqueSel (uniqueSel),
    .irShift   (irShift),
    .groupEn   (groupEn),
    .tdo       (tdo)
  );

  assign tdoEn = uniqueSel && (strobe.shiftIr || strobe.shiftDr);

endmodule

// File: rtl/mdSelChecker.sv
module mdSelChecker
  import mdSelPkg::*;
#(
  parameter int ADDR_BITS   = 6,
  parameter int GROUP_COUNT = 4
) (
  input logic                   tck,
  input logic                   trstN,
  input logic [ADDR_BITS-1:0]   slotId,
  input tapStrobe_t             strobe,
  input logic [ADDR_BITS-1:0]   irShift,
  input logic [GROUP_COUNT-1:0] groupEn,
  input logic                   uniqueSel,
  input logic                   selected,
  input logic                   tdoEn
);

  localparam int GROUP_BASE = (1 << ADDR_BITS) - 1 - GROUP_COUNT;

  a_r2_reset_clears: assert property (@(posedge tck) disable iff (!trstN)
    strobe.inReset |=> (!selected && groupEn == '0));

  a_r3_match_selects: assert property (@(posedge tck) disable iff (!trstN)
    (strobe.updateIr && irShift == slotId && irShift < ADDR_BITS'(GROUP_BASE))
      |=> (selected && uniqueSel));

  a_r4_mismatch_clears: assert property (@(posedge tck) disable iff (!trstN)
    (strobe.updateIr && irShift != slotId && irShift < ADDR_BITS'(GROUP_BASE))
      |=> !selected);

  a_r5_shared_quiet: assert property (@(posedge tck) disable iff (!trstN)
    (selected && !uniqueSel) |-> !tdoEn);

  a_r7_dr_ignored: assert property (@(posedge tck) disable iff (!trstN)
    (strobe.updateDr && !uniqueSel) |=> $stable(groupEn));

  a_r8_drive_in_shift: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (selected && (strobe.shiftIr || strobe.shiftDr)));

endmodule

bind mdAddrSelect mdSelChecker #(.ADDR_BITS(ADDR_BITS), .GROUP_COUNT(GROUP_COUNT)) chk (
  .tck       (tck),
  .trstN     (trstN),
  .slotId    (slotId),
  .strobe    (strobe),
  .irShift   (irShift),
  .groupEn   (groupEn),
  .uniqueSel (uniqueSel),
  .selected  (selected),
  .tdoEn     (tdoEn)
);

// File: tb/mdAddrSelect_test.sv
module mdAddrSelect_test;

  localparam time CLK_PERIOD = 20;
  localparam int  NVEC = 10;
  // {slot, code, expected selected}
  localparam logic [12:0] VECS [NVEC] = '{
    {6'd17, 6'd17, 1'b1},
    {6'd17, 6'd18, 1'b0},
    {6'd17, 6'd63, 1'b1},
    {6'd17, 6'd59, 1'b1},
    {6'd17, 6'd60, 1'b0},
    {6'd17, 6'd61, 1'b1},
    {6'd17, 6'd62, 1'b0},
    {6'd0,  6'd0,  1'b1},
    {6'd58, 6'd58, 1'b1},
    {6'd58, 6'd57, 1'b0}
  };

  logic tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [5:0] slotId = 6'd17;
  logic tdo, tdoEn, selected;

  int checks = 0, fails = 0;
  logic [5:0] irOut;
  logic [3:0] drOut;
  logic       enSeen;

  mdAddrSelect uut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .slotId(slotId),
    .tdo(tdo), .tdoEn(tdoEn), .selected(selected)
  );

  always #(CLK_PERIOD/2) tck = ~tck;

  task automatic check(string req, logic ok, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at falling edge, sample before the rising edge
  task automatic tick(logic tmsV, logic tdiV, output logic tdoS, output logic enS);
    tms = tmsV; tdi = tdiV;
    #1;
    tdoS = tdo; enS = tdoEn;
    @(posedge tck);
    @(negedge tck);
  endtask

  task automatic scanIr(logic [5:0] code);
    logic d, e;
    enSeen = 1'b0;
    tick(1, 0, d, e); tick(1, 0, d, e); tick(0, 0, d, e); tick(0, 0, d, e);
    for (int i = 0; i < 6; i++) begin
      tick(i == 5, code[i], d, e);
      irOut[i] = d;
      enSeen |= e;
    end
    tick(1, 0, d, e); tick(0, 0, d, e);
  endtask

  task automatic scanDr(logic [3:0] val);
    logic d, e;
    enSeen = 1'b0;
    tick(1, 0, d, e); tick(0, 0, d, e); tick(0, 0, d, e);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, val[i], d, e);
      drOut[i] = d;
      enSeen |= e;
    end
    tick(1, 0, d, e); tick(0, 0, d, e);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic d, e;
    logic prevUnique;
    @(negedge tck); @(negedge tck);
    check("R1 selected in reset", selected == 0, selected, 0);
    check("R1 tdoEn in reset", tdoEn == 0, tdoEn, 0);
    trstN = 1'b1;
    tick(0, 0, d, e);

    // unique select, then program groups
    scanIr(6'd17);
    check("R3 unique select", selected == 1, selected, 1);
    scanDr(4'b0101);
    check("R7 old group contents out", drOut == 4'b0000, drOut, 0);
    check("R8 drive in Shift-DR", enSeen == 1, enSeen, 1);
    scanDr(4'b0101);
    check("R7 committed contents out", drOut == 4'b0101, drOut, 5);

    // deselected DR scan is ignored and silent
    scanIr(6'd18);
    check("R4 mismatch clears", selected == 0, selected, 0);
    scanDr(4'b1111);
    check("R8 silent when deselected", enSeen == 0, enSeen, 0);
    scanIr(6'd17);
    check("R8 silent IR scan when deselected", enSeen == 0, enSeen, 0);
    scanDr(4'b0101);
    check("R7 register kept", drOut == 4'b0101, drOut, 5);

    // table walk
    prevUnique = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      slotId = VECS[v][12:7];
      scanIr(VECS[v][6:1]);
      check($sformatf("R3 R4 R5 R6 vec%0d selected", v),
            selected == VECS[v][0], selected, VECS[v][0]);
      check($sformatf("R5 R6 R8 vec%0d drive", v), enSeen == prevUnique, enSeen, prevUnique);
      if (prevUnique)
        check($sformatf("R9 vec%0d capture", v), irOut == 6'b000001, irOut, 1);
      prevUnique = VECS[v][0] && (VECS[v][6:1] < 6'd59);
    end

    // broadcast stays quiet through a further scan
    scanIr(6'd63);
    scanDr(4'b1111);
    check("R5 broadcast stays quiet", enSeen == 0, enSeen, 0);
    check("R5 broadcast selected", selected == 1, selected, 1);

    // TMS reset clears selection and groups
    slotId = 6'd17;
    scanIr(6'd17);
    check("R3 reselect", selected == 1, selected, 1);
    for (int i = 0; i < 5; i++) tick(1, 0, d, e);
    tick(0, 0, d, e);
    check("R2 tms reset clears", selected == 0, selected, 0);
    scanIr(6'd59);
    check("R2 groups cleared", selected == 0, selected, 0);

    // async reset mid shift
    scanIr(6'd17);
    tick(1, 0, d, e); tick(1, 0, d, e); tick(0, 0, d, e); tick(0, 0, d, e);
    #1;
    check("R8 drive in Shift-IR", tdoEn == 1, tdoEn, 1);
    trstN = 1'b0;
    #1;
    check("R1 async reset selected", selected == 0, selected, 0);
    check("R1 async reset tdoEn", tdoEn == 0, tdoEn, 0);
    @(negedge tck);
    trstN = 1'b1;
    tick(0, 0, d, e);
    scanIr(6'd17);
    check("R3 select after reset", selected == 1, selected, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule